// File: doc/BRIEF.md
# Security Alarm and Reset Controller

This block gathers the one-cycle alarm pulses raised by a chip's environmental detectors, memory checkers and bus monitors, and sorts every pulse into one of two responses. A fatal alarm stops the system: the controller enters a halted state, drives both of its reset outputs and keeps them driven until an external power-on reset arrives. Nothing software does can leave that state. A recoverable alarm stops nothing. It marks a pending cause and raises an interrupt line, so that software can deal with the event and then acknowledge it.

Fatal sources arrive as one vector, one bit per detector: temperature, clock frequency, supply level, supply glitch, light sensor, address area violation, duplicated signal mismatch, memory firewall violation, active shield error and RAM parity error. The non-volatile memory reports a two-bit ECC status on each read. An undefined instruction arrives as a pulse together with a kind bit that selects between the recoverable and the fatal response. The controller shows a sticky cause vector, with one bit per source. Fatal cause bits can only be cleared by power-on reset. Recoverable cause bits are cleared by a write-one-to-clear strobe.

Top module: `alarm_reset_ctrl`

## Requirements
- R1: While `por_i` is high at a clock edge, that edge clears `cause_o`, `halt_o`, `rst_o`, `irq_o` and `nmi_o` to zero.
- R2: A pulse on any bit of `fatal_i` sets `halt_o` to 1 and `rst_o` to 2'b11 after the next edge. Bit 0 of `rst_o` resets the RF interface and the crypto coprocessor. Bit 1 of `rst_o` resets the CPU.
- R3: Once `halt_o` is 1, it stays 1 and `rst_o` stays 2'b11 on every cycle until an edge with `por_i` high. Clear writes have no effect on this state.
- R4: `cause_o[i]` for i in 0..9 records `fatal_i[i]`. The order of these bits is: temperature, clock, supply, glitch, light, address area, duplicate mismatch, firewall, shield, RAM parity. Each bit is sticky until power-on reset.
- R5: An `undef_i` pulse with `undef_kind_i`=1 is fatal. It sets `cause_o[10]` and acts as in R2.
- R6: An ECC status of 2'b10 or 2'b11 on `nvm_ecc_i` (two or more bits in error) sets `cause_o[11]` and `irq_o` after the next edge. It does not assert any reset.
- R7: An `undef_i` pulse with `undef_kind_i`=0 sets `cause_o[12]` and `nmi_o` after the next edge. It does not assert any reset.
- R8: An ECC status of 2'b01 (single bit, corrected) or 2'b00 changes no output.
- R9: `clr_en_i` with `clr_mask_i[0]` clears `cause_o[11]` and `irq_o`, and `clr_mask_i[1]` clears `cause_o[12]` and `nmi_o`, after the next edge. A mask bit of 0 leaves its cause bit as it is.
- R10: When a recoverable event and its clear fall in the same cycle, the event wins and the cause bit stays set.
- R11: A fatal alarm leaves the recoverable cause bits, `irq_o` and `nmi_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| fatal_i | input | 10 | One-cycle fatal detector pulses, one bit per source |
| nvm_ecc_i | input | 2 | ECC status of the non-volatile memory read: 00 clean, 01 corrected, 1x uncorrectable |
| undef_i | input | 1 | Undefined instruction pulse |
| undef_kind_i | input | 1 | Kind of undefined instruction: 0 recoverable, 1 fatal |
| clr_en_i | input | 1 | Write strobe that clears recoverable causes |
| clr_mask_i | input | 2 | Write-one-to-clear mask: bit 0 ECC cause, bit 1 soft undefined cause |
| cause_o | output | 13 | Sticky cause vector |
| halt_o | output | 1 | System halted by a fatal alarm |
| rst_o | output | 2 | Reset outputs: bit 0 RF and coprocessor, bit 1 CPU |
| irq_o | output | 1 | Uncorrectable memory error interrupt |
| nmi_o | output | 1 | Non-maskable interrupt for a soft undefined instruction |

## Verification
The hardest situation to reach is a recoverable event and its clear landing on the same edge while a fatal alarm is already latched. Random traffic rarely lines these up. A fatal pulse also ends any useful random run, because its state lasts until power-on reset. For these reasons the random phase injects fatal pulses only rarely and issues power-on resets now and then, so that the model re-arms. A directed sequence first latches a fatal source, then drives an ECC event, a soft undefined pulse and an all-ones clear in the same cycle. Each fatal source is also taken once, on its own, between power-on resets.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  // number of external fatal detector inputs
  localparam int unsigned N_FATAL_IN = 10;
  // fatal cause bits: external ones plus the fatal undefined-instruction case
  localparam int unsigned N_FATAL    = N_FATAL_IN + 1;
  // recoverable causes: uncorrectable ECC, soft undefined instruction
  localparam int unsigned N_REC      = 2;
  localparam int unsigned N_CAUSE    = N_FATAL + N_REC;
  localparam int unsigned N_RST      = 2;

  localparam int unsigned REC_ECC    = 0;
  localparam int unsigned REC_UNDEF  = 1;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'b00,
    ECC_FIXED = 2'b01,
    ECC_DUAL  = 2'b10,
    ECC_MULTI = 2'b11
  } ecc_state_e;

endpackage

// File: rtl/alarm_classify.sv
module alarm_classify
  import alarm_pkg::*;
#(
  parameter int unsigned FIN = N_FATAL_IN
) (
  input  logic [FIN-1:0]   fatal_i,
  input  logic [1:0]       nvm_ecc_i,
  input  logic             undef_i,
  input  logic             undef_kind_i,
  output logic [FIN:0]     fatal_ev_o,
  output logic [N_REC-1:0] rec_ev_o
);

  ecc_state_e ecc_st;
  logic       ecc_bad;

  always_comb begin
    ecc_st = ecc_state_e'(nvm_ecc_i);
    unique case (ecc_st)
      ECC_DUAL, ECC_MULTI: ecc_bad = 1'b1;
      default:             ecc_bad = 1'b0;  // clean or silently corrected
    endcase
  end

  always_comb begin
    fatal_ev_o             = {undef_i & undef_kind_i, fatal_i};
    rec_ev_o               = '0;
    rec_ev_o[REC_ECC]      = ecc_bad;
    rec_ev_o[REC_UNDEF]    = undef_i & ~undef_kind_i;
  end

endmodule

// File: rtl/fatal_capture.sv
module fatal_capture
  import alarm_pkg::*;
#(
  parameter int unsigned NF = N_FATAL,
  parameter int unsigned NR = N_RST
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic [NF-1:0] fatal_ev_i,
  output logic [NF-1:0] sticky_o,
  output logic          halt_o,
  output logic [NR-1:0] rst_o
);

  logic [NF-1:0] sticky_q;
  logic          halt_q;
  logic [NR-1:0] rst_q;
  logic          any_ev;

  assign any_ev = |fatal_ev_i;

  always_ff @(posedge clk) begin
    if (por_i) begin
      sticky_q <= '0;
      halt_q   <= 1'b0;
      rst_q    <= '0;
    end else begin
      sticky_q <= sticky_q | fatal_ev_i;
      if (any_ev) halt_q <= 1'b1;
      rst_q    <= (halt_q || any_ev) ? '1 : '0;
    end
  end

  assign sticky_o = sticky_q;
  assign halt_o   = halt_q;
  assign rst_o    = rst_q;

  // R2
  fatal_rst_chk: assert property (@(posedge clk) disable iff (por_i)
    any_ev |=> (halt_q && rst_q == '1));

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (por_i)
    halt_q |=> (halt_q && rst_q == '1));

  for (genvar g = 0; g < NF; g++) begin : g_stk
    // R4
    cause_sticky_chk: assert property (@(posedge clk) disable iff (por_i)
      sticky_q[g] |=> sticky_q[g]);
  end

endmodule

// File: rtl/recov_cause.sv
module recov_cause
  import alarm_pkg::*;
#(
  parameter int unsigned NRC = N_REC
) (
  input  logic           clk,
  input  logic           por_i,
  input  logic [NRC-1:0] rec_ev_i,
  input  logic           clr_en_i,
  input  logic [NRC-1:0] clr_mask_i,
  output logic [NRC-1:0] pend_o
);

  logic [NRC-1:0] pend_q;

  for (genvar g = 0; g < NRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (por_i)                          pend_q[g] <= 1'b0;
      else if (rec_ev_i[g])               pend_q[g] <= 1'b1;
      else if (clr_en_i && clr_mask_i[g]) pend_q[g] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (por_i)
      rec_ev_i[g] |=> pend_q[g]);

    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (por_i)
      (clr_en_i && clr_mask_i[g] && !rec_ev_i[g]) |=> !pend_q[g]);

    // R9
    keep_chk: assert property (@(posedge clk) disable iff (por_i)
      (pend_q[g] && !(clr_en_i && clr_mask_i[g])) |=> pend_q[g]);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/alarm_reset_ctrl.sv
module alarm_reset_ctrl
  import alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  por_i,
  input  logic [N_FATAL_IN-1:0] fatal_i,
  input  logic [1:0]            nvm_ecc_i,
  input  logic                  undef_i,
  input  logic                  undef_kind_i,
  input  logic                  clr_en_i,
  input  logic [N_REC-1:0]      clr_mask_i,
  output logic [N_CAUSE-1:0]    cause_o,
  output logic                  halt_o,
  output logic [N_RST-1:0]      rst_o,
  output logic                  irq_o,
  output logic                  nmi_o
);

  logic [N_FATAL-1:0] fatal_ev;
  logic [N_REC-1:0]   rec_ev;
  logic [N_FATAL-1:0] fatal_stk;
  logic [N_REC-1:0]   rec_pend;

  alarm_classify #(.FIN(N_FATAL_IN)) u_cls (
    .fatal_i      (fatal_i),
    .nvm_ecc_i    (nvm_ecc_i),
    .undef_i      (undef_i),
    .undef_kind_i (undef_kind_i),
    .fatal_ev_o   (fatal_ev),
    .rec_ev_o     (rec_ev)
  );

  fatal_capture #(.NF(N_FATAL), .NR(N_RST)) u_fat (
    .clk        (clk),
    .por_i      (por_i),
    .fatal_ev_i (fatal_ev),
    .sticky_o   (fatal_stk),
    .halt_o     (halt_o),
    .rst_o      (rst_o)
  );

  recov_cause #(.NRC(N_REC)) u_rec (
    .clk        (clk),
    .por_i      (por_i),
    .rec_ev_i   (rec_ev),
    .clr_en_i   (clr_en_i),
    .clr_mask_i (clr_mask_i),
    .pend_o     (rec_pend)
  );

  assign cause_o = {rec_pend, fatal_stk};
  assign irq_o   = rec_pend[REC_ECC];
  assign nmi_o   = rec_pend[REC_UNDEF];

  // R1
  por_clear_chk: assert property (@(posedge clk)
    por_i |=> (cause_o == '0 && !halt_o && rst_o == '0));

  // R6
  ecc_no_rst_chk: assert property (@(posedge clk) disable iff (por_i)
    (!halt_o && fatal_ev == '0 && nvm_ecc_i[1]) |=> (irq_o && rst_o == '0));

endmodule

// File: tb/tb_alarm_reset_ctrl.sv
module tb_alarm_reset_ctrl;
  import alarm_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic                  por_i = 1'b1;
  logic [N_FATAL_IN-1:0] fatal_i = '0;
  logic [1:0]            nvm_ecc_i = 2'b00;
  logic                  undef_i = 1'b0;
  logic                  undef_kind_i = 1'b0;
  logic                  clr_en_i = 1'b0;
  logic [N_REC-1:0]      clr_mask_i = '0;
  logic [N_CAUSE-1:0]    cause_o;
  logic                  halt_o;
  logic [N_RST-1:0]      rst_o;
  logic                  irq_o;
  logic                  nmi_o;

  alarm_reset_ctrl dut (.*);

  int tests = 0;
  int fails = 0;

  logic [N_CAUSE-1:0] exp_cause = '0;
  logic               exp_halt  = 1'b0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // reference model of one clock edge
  function automatic logic [N_CAUSE:0] model(
      input logic [N_CAUSE-1:0] c, input logic h, input logic por,
      input logic [N_FATAL_IN-1:0] f, input logic [1:0] ecc,
      input logic u, input logic uk, input logic ce, input logic [1:0] cm);
    logic [N_CAUSE-1:0] n;
    logic               nh;
    logic               ev_e, ev_u;
    if (por) return '0;
    n = c;
    n[N_FATAL_IN-1:0] = c[N_FATAL_IN-1:0] | f;
    if (u && uk) n[10] = 1'b1;
    nh = h | (|f) | (u & uk);
    ev_e = (ecc == 2'b10) || (ecc == 2'b11);
    ev_u = u & ~uk;
    if (ev_e) n[11] = 1'b1; else if (ce && cm[0]) n[11] = 1'b0;
    if (ev_u) n[12] = 1'b1; else if (ce && cm[1]) n[12] = 1'b0;
    return {nh, n};
  endfunction

  task automatic step(input string tag);
    logic [N_CAUSE:0] r;
    @(posedge clk);
    r = model(exp_cause, exp_halt, por_i, fatal_i, nvm_ecc_i, undef_i,
              undef_kind_i, clr_en_i, clr_mask_i);
    exp_halt  = r[N_CAUSE];
    exp_cause = r[N_CAUSE-1:0];
    #2;
    check({tag, " cause"}, 32'(cause_o), 32'(exp_cause));
    check({tag, " halt"},  32'(halt_o),  32'(exp_halt));
    check({tag, " rst"},   32'(rst_o),   exp_halt ? 32'd3 : 32'd0);
    check({tag, " irq"},   32'(irq_o),   32'(exp_cause[11]));
    check({tag, " nmi"},   32'(nmi_o),   32'(exp_cause[12]));
  endtask

  task automatic drive(input logic p, input logic [N_FATAL_IN-1:0] f,
                       input logic [1:0] e, input logic u, input logic uk,
                       input logic ce, input logic [1:0] cm);
    @(negedge clk);
    por_i = p; fatal_i = f; nvm_ecc_i = e; undef_i = u;
    undef_kind_i = uk; clr_en_i = ce; clr_mask_i = cm;
  endtask

  task automatic idle();
    drive(1'b0, '0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_a1a7));
    // R1: reset state
    drive(1'b1, '0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00);
    step("R1 por");
    step("R1 por");

    // R2 R4: each fatal source on its own
    for (int i = 0; i < N_FATAL_IN; i++) begin
      drive(1'b1, '0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00); step("R1 por");
      drive(1'b0, 10'(1) << i, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00); step("R2 R4 fatal");
      idle(); step("R3 hold");
      check("R4 single cause", 32'(cause_o), 32'(1) << i);
    end

    // R5: fatal undefined instruction; R3 clears ignored
    drive(1'b1, '0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00); step("R1 por");
    drive(1'b0, '0, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00); step("R5 undef fatal");
    check("R5 bit10", 32'(cause_o), 32'h400);
    drive(1'b0, '0, 2'b00, 1'b0, 1'b0, 1'b1, 2'b11); step("R3 clear ignored");
    check("R3 rst held", 32'(rst_o), 32'd3);

    // R6 R7 R8 R9 R10 R11
    drive(1'b1, '0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00); step("R1 por");
    drive(1'b0, '0, 2'b01, 1'b0, 1'b0, 1'b0, 2'b00); step("R8 corrected");
    check("R8 no cause", 32'(cause_o), 32'd0);
    drive(1'b0, '0, 2'b10, 1'b0, 1'b0, 1'b0, 2'b00); step("R6 ecc");
    check("R6 no rst", 32'(rst_o), 32'd0);
    drive(1'b0, '0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00); step("R7 soft undef");
    check("R7 nmi", 32'(nmi_o), 32'd1);
    drive(1'b0, '0, 2'b00, 1'b0, 1'b0, 1'b1, 2'b00); step("R9 zero mask keeps");
    drive(1'b0, '0, 2'b00, 1'b0, 1'b0, 1'b1, 2'b01); step("R9 clear ecc");
    check("R9 irq low", 32'(irq_o), 32'd0);
    drive(1'b0, '0, 2'b11, 1'b0, 1'b0, 1'b1, 2'b11); step("R10 set wins");
    check("R10 irq", 32'(irq_o), 32'd1);
    drive(1'b0, 10'h200, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00); step("R11 fatal keeps rec");
    check("R11 irq kept", 32'(irq_o), 32'd1);
    drive(1'b0, '0, 2'b11, 1'b1, 1'b0, 1'b1, 2'b11); step("R10 R11 under halt");
    drive(1'b0, '0, 2'b00, 1'b0, 1'b0, 1'b1, 2'b11); step("R9 R3 clear under halt");

    // random phase
    drive(1'b1, '0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00); step("R1 por");
    for (int k = 0; k < 3000; k++) begin
      logic [N_FATAL_IN-1:0] f;
      f = '0;
      if ($urandom_range(0, 99) == 0) f = 10'(1) << $urandom_range(0, N_FATAL_IN - 1);
      drive($urandom_range(0, 149) == 0, f, 2'($urandom_range(0, 3)),
            $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0,
            $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)));
      step("R2 R6 R7 R9 random");
    end

    idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule